// File: doc/BRIEF.md
# PHY Test-Register Port

This block is the PHY-side target of a slow, software-driven test port. Four pins program a small bank of 8-bit configuration registers. The pins are a test clock, a test clear, a test enable and an 8-bit data input. An 8-bit data output reads back the bank.

Register codes and register data travel on the same 8-bit input. The only things that tell them apart are the level of the enable pin and which edge of the test clock occurs:
- A falling test-clock edge with enable high takes the byte as the register code.
- A rising edge with enable low commits the byte into the register that was selected.

The pins are driven from software at a low rate. They are sampled by the PHY's own clock `clk` through a synchronizer, and the edges are found in that clock domain.

Two registers are written in halves: bit 7 of the written byte chooses the half. The block decodes the PLL divider, frequency-range, bias/bandgap selector and timing-override fields and drives them as outputs.

Top module: `phy_tst_port`

## Requirements
- R1: A falling edge of `tstClk` while `tstEn` is high stores `tstDin` as the selected code. From then on `tstDout` shows that register's contents, with unimplemented bits reading 0.
- R2: A falling edge of `tstClk` while `tstEn` is low leaves the selected code unchanged.
- R3: A rising edge of `tstClk` while `tstEn` is low writes `tstDin` into the selected register. A rising edge while `tstEn` is high writes nothing.
- R4: While `rstN` is low, or while `tstClr` is high, every register, every half and the selected code are zero. Test-clock edges seen while `tstClr` is high have no effect.
- R5: Code 0x17 bits 6:0 drive `inDivM1`. Code 0x19 bit 5 drives `loopDivEn` and bit 4 drives `inDivEn`.
- R6: Code 0x18 is written in halves.
  - With bit 7 = 0, bits 4:0 go to `loopDivM1[4:0]`; with bit 7 = 1, they go to `loopDivM1[9:5]`. The other half is kept.
  - Read-back shows the last byte written, masked to bit 7 and bits 4:0.
- R7: Code 0x44 bits 6:1 drive `freqRange`.
- R8: Code 0x22 is written in halves.
  - With bit 7 = 0, bits 2:0 go to `biasSel`; with bit 7 = 1, they go to `bandgapSel`.
  - Read-back is the last byte masked to bit 7 and bits 2:0.
- R9: Codes 0x70 and 0x71 each hold an enable in bit 7 and a 7-bit value in bits 6:0. Code 0x72 holds an enable in bit 6 and a 6-bit value in bits 5:0; its bit 7 is reserved.
- R10: A write to a code other than 0x17, 0x18, 0x19, 0x22, 0x44, 0x70, 0x71 or 0x72 changes no output, and such a code reads back 0. Reserved bits read 0.
- R11: A pin change is reflected on the outputs within three `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tstClk | input | 1 | Test clock pin |
| tstClr | input | 1 | Test clear pin, active high |
| tstEn | input | 1 | Test enable: high selects code capture |
| tstDin | input | 8 | Shared code/data byte |
| tstDout | output | 8 | Contents of the selected register |
| loopDivM1 | output | 10 | Loop divider minus one |
| loopDivEn | output | 1 | Loop divider program enable |
| inDivM1 | output | 7 | Input divider minus one |
| inDivEn | output | 1 | Input divider program enable |
| freqRange | output | 6 | High-speed frequency range select |
| biasSel | output | 3 | Bias selector (low half of 0x22) |
| bandgapSel | output | 3 | Bandgap selector (high half of 0x22) |
| tlpOvrEn | output | 1 | LP timing override enable |
| tlpOvr | output | 7 | LP timing override value |
| thsPreOvrEn | output | 1 | HS prepare override enable |
| thsPreOvr | output | 7 | HS prepare override value |
| thsZeroOvrEn | output | 1 | HS zero override enable |
| thsZeroOvr | output | 6 | HS zero override value |

## Verification
The bench checks the wrong-edge cases:
- A rising edge with enable high must not write. A design that ignores the enable there would overwrite the selected register with the code byte.
- A falling edge with enable low must not reselect. A design that gets this wrong would retarget the following write.

For the split registers, the bench writes one half and then the other. A design that clears the unwritten half, or ignores bit 7, shows the wrong divider or selector.

Writes to unimplemented codes and to reserved bits are checked through read-back and through every field output. Test clear is driven together with live clock edges to show that it wins.

// File: rtl/phy_tst_pkg.sv
package phy_tst_pkg;

  localparam int TST_W    = 8;
  localparam int NUM_REGS = 8;

  localparam logic [TST_W-1:0] CODE_INDIV   = 8'h17;
  localparam logic [TST_W-1:0] CODE_LOOPDIV = 8'h18;
  localparam logic [TST_W-1:0] CODE_DIVEN   = 8'h19;
  localparam logic [TST_W-1:0] CODE_BIASBG  = 8'h22;
  localparam logic [TST_W-1:0] CODE_FREQ    = 8'h44;
  localparam logic [TST_W-1:0] CODE_TLP     = 8'h70;
  localparam logic [TST_W-1:0] CODE_THSPRE  = 8'h71;
  localparam logic [TST_W-1:0] CODE_THSZERO = 8'h72;

  typedef struct packed {
    logic latchAddr;
    logic commitData;
    logic clearAll;
  } tstStrobe_t;

  function automatic logic [TST_W-1:0] codeOf(input int idx);
    case (idx)
      0: codeOf = CODE_INDIV;
      1: codeOf = CODE_LOOPDIV;
      2: codeOf = CODE_DIVEN;
      3: codeOf = CODE_BIASBG;
      4: codeOf = CODE_FREQ;
      5: codeOf = CODE_TLP;
      6: codeOf = CODE_THSPRE;
      default: codeOf = CODE_THSZERO;
    endcase
  endfunction

  function automatic logic [TST_W-1:0] maskOf(input int idx);
    case (idx)
      0: maskOf = 8'h7F;
      1: maskOf = 8'h9F;
      2: maskOf = 8'h30;
      3: maskOf = 8'h87;
      4: maskOf = 8'h7E;
      5: maskOf = 8'hFF;
      6: maskOf = 8'hFF;
      default: maskOf = 8'h7F;
    endcase
  endfunction

endpackage

// File: rtl/phy_tst_ctrl.sv
module phy_tst_ctrl
  import phy_tst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tstClk,
  input  logic             tstClr,
  input  logic             tstEn,
  input  logic [TST_W-1:0] tstDin,
  output tstStrobe_t       strobe,
  output logic [TST_W-1:0] byteS
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0]            clkSync;
  logic [SYNC_STAGES-1:0]            clrSync;
  logic [SYNC_STAGES-1:0]            enSync;
  logic [SYNC_STAGES-1:0][TST_W-1:0] dinSync;
  logic                              clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      clrSync <= '0;
      enSync  <= '0;
      dinSync <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkSync[0] <= tstClk;
      clrSync[0] <= tstClr;
      enSync[0]  <= tstEn;
      dinSync[0] <= tstDin;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        clkSync[s] <= clkSync[s-1];
        clrSync[s] <= clrSync[s-1];
        enSync[s]  <= enSync[s-1];
        dinSync[s] <= dinSync[s-1];
      end
      clkPrev <= clkSync[LAST];
    end
  end

  logic fallEdge, riseEdge;

  always_comb begin
    fallEdge          = clkPrev & ~clkSync[LAST];
    riseEdge          = ~clkPrev & clkSync[LAST];
    strobe.clearAll   = clrSync[LAST];
    strobe.latchAddr  = fallEdge & enSync[LAST] & ~clrSync[LAST];
    strobe.commitData = riseEdge & ~enSync[LAST] & ~clrSync[LAST];
    byteS             = dinSync[LAST];
  end

endmodule

// File: rtl/phy_tst_regs.sv
module phy_tst_regs
  import phy_tst_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  tstStrobe_t                     strobe,
  input  logic [TST_W-1:0]               byteS,
  output logic [TST_W-1:0]               addrQ,
  output logic [NUM_REGS-1:0][TST_W-1:0] regQ,
  output logic [TST_W-1:0]               readByte
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (strobe.clearAll) addrQ <= '0;
    else if (strobe.latchAddr) addrQ <= byteS;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
    localparam logic [TST_W-1:0] MY_CODE = codeOf(i);
    localparam logic [TST_W-1:0] MY_MASK = maskOf(i);
    logic hit;
    assign hit = strobe.commitData && (addrQ == MY_CODE);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ[i] <= '0;
      else if (strobe.clearAll) regQ[i] <= '0;
      else if (hit) regQ[i] <= byteS & MY_MASK;
    end
  end

  always_comb begin
    readByte = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addrQ == codeOf(i)) readByte = readByte | regQ[i];
    end
  end

endmodule

// File: rtl/phy_tst_fields.sv
module phy_tst_fields
  import phy_tst_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  tstStrobe_t                     strobe,
  input  logic [TST_W-1:0]               byteS,
  input  logic [TST_W-1:0]               addrQ,
  input  logic [NUM_REGS-1:0][TST_W-1:0] regQ,
  output logic [9:0]                     loopDivM1,
  output logic                           loopDivEn,
  output logic [6:0]                     inDivM1,
  output logic                           inDivEn,
  output logic [5:0]                     freqRange,
  output logic [2:0]                     biasSel,
  output logic [2:0]                     bandgapSel,
  output logic                           tlpOvrEn,
  output logic [6:0]                     tlpOvr,
  output logic                           thsPreOvrEn,
  output logic [6:0]                     thsPreOvr,
  output logic                           thsZeroOvrEn,
  output logic [5:0]                     thsZeroOvr
);

  logic [4:0] loopLo, loopHi;
  logic [2:0] biasQ, bandQ;
  logic       hitLoop, hitBias;

  assign hitLoop = strobe.commitData && (addrQ == CODE_LOOPDIV);
  assign hitBias = strobe.commitData && (addrQ == CODE_BIASBG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopLo <= '0;
      loopHi <= '0;
      biasQ  <= '0;
      bandQ  <= '0;
    end else if (strobe.clearAll) begin
      loopLo <= '0;
      loopHi <= '0;
      biasQ  <= '0;
      bandQ  <= '0;
    end else begin
      if (hitLoop) begin
        if (byteS[7]) loopHi <= byteS[4:0];
        else          loopLo <= byteS[4:0];
      end
      if (hitBias) begin
        if (byteS[7]) bandQ <= byteS[2:0];
        else          biasQ <= byteS[2:0];
      end
    end
  end

  always_comb begin
    loopDivM1    = {loopHi, loopLo};
    biasSel      = biasQ;
    bandgapSel   = bandQ;
    inDivM1      = regQ[0][6:0];
    loopDivEn    = regQ[2][5];
    inDivEn      = regQ[2][4];
    freqRange    = regQ[4][6:1];
    tlpOvrEn     = regQ[5][7];
    tlpOvr       = regQ[5][6:0];
    thsPreOvrEn  = regQ[6][7];
    thsPreOvr    = regQ[6][6:0];
    thsZeroOvrEn = regQ[7][6];
    thsZeroOvr   = regQ[7][5:0];
  end

endmodule

// File: rtl/phy_tst_port.sv
module phy_tst_port
  import phy_tst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tstClk,
  input  logic       tstClr,
  input  logic       tstEn,
  input  logic [7:0] tstDin,
  output logic [7:0] tstDout,
  output logic [9:0] loopDivM1,
  output logic       loopDivEn,
  output logic [6:0] inDivM1,
  output logic       inDivEn,
  output logic [5:0] freqRange,
  output logic [2:0] biasSel,
  output logic [2:0] bandgapSel,
  output logic       tlpOvrEn,
  output logic [6:0] tlpOvr,
  output logic       thsPreOvrEn,
  output logic [6:0] thsPreOvr,
  output logic       thsZeroOvrEn,
  output logic [5:0] thsZeroOvr
);

  tstStrobe_t                     strobe;
  logic [TST_W-1:0]               byteS;
  logic [TST_W-1:0]               addrQ;
  logic [NUM_REGS-1:0][TST_W-1:0] regQ;
  logic                           latchW, commitW, clearW;

  assign latchW  = strobe.latchAddr;
  assign commitW = strobe.commitData;
  assign clearW  = strobe.clearAll;

  phy_tst_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tstClk(tstClk), .tstClr(tstClr),
    .tstEn(tstEn), .tstDin(tstDin), .strobe(strobe), .byteS(byteS)
  );

  phy_tst_regs u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteS(byteS),
    .addrQ(addrQ), .regQ(regQ), .readByte(tstDout)
  );

  phy_tst_fields u_fields (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteS(byteS),
    .addrQ(addrQ), .regQ(regQ),
    .loopDivM1(loopDivM1), .loopDivEn(loopDivEn),
    .inDivM1(inDivM1), .inDivEn(inDivEn), .freqRange(freqRange),
    .biasSel(biasSel), .bandgapSel(bandgapSel),
    .tlpOvrEn(tlpOvrEn), .tlpOvr(tlpOvr),
    .thsPreOvrEn(thsPreOvrEn), .thsPreOvr(thsPreOvr),
    .thsZeroOvrEn(thsZeroOvrEn), .thsZeroOvr(thsZeroOvr)
  );

endmodule

// File: rtl/phy_tst_port_chk.sv
module phy_tst_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       latchAddr,
  input logic       commitData,
  input logic       clearAll,
  input logic [7:0] byteS,
  input logic [7:0] addrQ,
  input logic [7:0] tstDout,
  input logic [9:0] loopDivM1,
  input logic [6:0] inDivM1,
  input logic [5:0] freqRange
);

  logic unimpl;
  assign unimpl = (addrQ != 8'h17) && (addrQ != 8'h18) && (addrQ != 8'h19) &&
                  (addrQ != 8'h22) && (addrQ != 8'h44) && (addrQ != 8'h70) &&
                  (addrQ != 8'h71) && (addrQ != 8'h72);

  a_r1_code_capture: assert property (@(posedge clk) disable iff (!rstN)
    latchAddr |=> addrQ == $past(byteS));

  a_r2_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!latchAddr && !clearAll) |=> $stable(addrQ));

  a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!commitData && !clearAll) |=> ($stable(loopDivM1) && $stable(inDivM1) && $stable(freqRange)));

  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (addrQ == 8'h00 && tstDout == 8'h00 && loopDivM1 == 10'd0));

  a_r7_freq_write: assert property (@(posedge clk) disable iff (!rstN)
    (commitData && addrQ == 8'h44) |=> freqRange == $past(byteS[6:1]));

  a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    unimpl |-> tstDout == 8'h00);

endmodule

bind phy_tst_port phy_tst_port_chk u_chk (
  .clk(clk), .rstN(rstN), .latchAddr(latchW), .commitData(commitW),
  .clearAll(clearW), .byteS(byteS), .addrQ(addrQ), .tstDout(tstDout),
  .loopDivM1(loopDivM1), .inDivM1(inDivM1), .freqRange(freqRange)
);

// File: tb/phy_tst_port_test.sv
module phy_tst_port_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tstClk = 1'b1, tstClr = 1'b0, tstEn = 1'b1;
  logic [7:0] tstDin = 8'h00;
  logic [7:0] tstDout;
  logic [9:0] loopDivM1;
  logic loopDivEn, inDivEn, tlpOvrEn, thsPreOvrEn, thsZeroOvrEn;
  logic [6:0] inDivM1, tlpOvr, thsPreOvr;
  logic [5:0] freqRange, thsZeroOvr;
  logic [2:0] biasSel, bandgapSel;

  int nRun = 0, nFail = 0;

  always #5 clk = ~clk;

  phy_tst_port uut (
    .clk(clk), .rstN(rstN), .tstClk(tstClk), .tstClr(tstClr), .tstEn(tstEn),
    .tstDin(tstDin), .tstDout(tstDout), .loopDivM1(loopDivM1), .loopDivEn(loopDivEn),
    .inDivM1(inDivM1), .inDivEn(inDivEn), .freqRange(freqRange), .biasSel(biasSel),
    .bandgapSel(bandgapSel), .tlpOvrEn(tlpOvrEn), .tlpOvr(tlpOvr),
    .thsPreOvrEn(thsPreOvrEn), .thsPreOvr(thsPreOvr),
    .thsZeroOvrEn(thsZeroOvrEn), .thsZeroOvr(thsZeroOvr)
  );

  logic [7:0] mdl [0:255];
  logic [4:0] mLoLo, mLoHi;
  logic [2:0] mBias, mBand;

  function automatic logic [7:0] maskFor(input logic [7:0] a);
    case (a)
      8'h17: return 8'h7F;
      8'h18: return 8'h9F;
      8'h19: return 8'h30;
      8'h22: return 8'h87;
      8'h44: return 8'h7E;
      8'h70: return 8'hFF;
      8'h71: return 8'hFF;
      8'h72: return 8'h7F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] pickCode(input int k);
    case (k)
      0: return 8'h17;
      1: return 8'h18;
      2: return 8'h19;
      3: return 8'h22;
      4: return 8'h44;
      5: return 8'h70;
      6: return 8'h71;
      default: return 8'h72;
    endcase
  endfunction

  task automatic modelClear();
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    mLoLo = '0; mLoHi = '0; mBias = '0; mBand = '0;
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] d);
    mdl[a] = d & maskFor(a);
    if (a == 8'h18) begin if (d[7]) mLoHi = d[4:0]; else mLoLo = d[4:0]; end
    if (a == 8'h22) begin if (d[7]) mBand = d[2:0]; else mBias = d[2:0]; end
  endtask

  function automatic logic [65:0] expFields();
    return {mLoHi, mLoLo, mdl[8'h19][5], mdl[8'h17][6:0], mdl[8'h19][4],
            mdl[8'h44][6:1], mBias, mBand, mdl[8'h70][7], mdl[8'h70][6:0],
            mdl[8'h71][7], mdl[8'h71][6:0], mdl[8'h72][6], mdl[8'h72][5:0]};
  endfunction

  function automatic logic [65:0] actFields();
    return {loopDivM1, loopDivEn, inDivM1, inDivEn, freqRange, biasSel, bandgapSel,
            tlpOvrEn, tlpOvr, thsPreOvrEn, thsPreOvr, thsZeroOvrEn, thsZeroOvr};
  endfunction

  task automatic check(input bit ok, input string req, input logic [65:0] act,
                       input logic [65:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Falling edge with enable high selects the code (R1)
  task automatic selectCode(input logic [7:0] a);
    tstClk = 1'b1; tstEn = 1'b1; tstDin = a; settle();
    tstClk = 1'b0; settle();
  endtask

  task automatic phyWrite(input logic [7:0] a, input logic [7:0] d);
    selectCode(a);
    tstEn = 1'b0; tstDin = d; settle();
    tstClk = 1'b1; settle();
    tstEn = 1'b1;
    modelWrite(a, d);
  endtask

  function automatic string reqFor(input logic [7:0] a);
    case (a)
      8'h17, 8'h19: return "R5";
      8'h18: return "R6";
      8'h44: return "R7";
      8'h22: return "R8";
      8'h70, 8'h71, 8'h72: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    // R4 reset state
    check(tstDout == 8'h00, "R4 reset dout", 66'(tstDout), 66'h0);
    check(actFields() == expFields(), "R4 reset fields", actFields(), expFields());

    // R11: latency of three clk cycles after the pin change
    selectCode(8'h44);
    tstEn = 1'b0; tstDin = 8'h2A; settle();
    tstClk = 1'b1;
    repeat (3) @(negedge clk);
    check(freqRange == 6'h15, "R11 latency", 66'(freqRange), 66'h15);
    settle(); tstEn = 1'b1;
    modelWrite(8'h44, 8'h2A);
    check(tstDout == 8'h2A, "R1 readback 0x44", 66'(tstDout), 66'h2A);

    // R3: rising edge with enable high writes nothing; R2: falling edge with enable low keeps the code
    selectCode(8'h70);
    tstEn = 1'b1; tstDin = 8'hC3; tstClk = 1'b1; settle();
    check(tstDout == 8'h00 && tlpOvr == 7'h0, "R3 rise with enable high", 66'(tstDout), 66'h0);
    tstClk = 1'b0; tstEn = 1'b0; tstDin = 8'h71; settle();
    tstDin = 8'h8B; tstClk = 1'b1; settle(); tstEn = 1'b1;
    modelWrite(8'h70, 8'h8B);
    check(tstDout == 8'h8B, "R2 code kept over low-enable fall", 66'(tstDout), 66'h8B);
    check(actFields() == expFields(), "R3 write lands", actFields(), expFields());

    // R6: split loop divider
    phyWrite(8'h18, 8'h1F);
    phyWrite(8'h18, 8'h85);
    check(loopDivM1 == {5'd5, 5'd31}, "R6 both halves", 66'(loopDivM1), 66'h0BF);
    check(tstDout == 8'h85, "R6 readback", 66'(tstDout), 66'h85);
    phyWrite(8'h18, 8'h63);
    check(loopDivM1 == {5'd5, 5'd3}, "R6 high half kept", 66'(loopDivM1), 66'h0A3);

    // R8: split selectors
    phyWrite(8'h22, 8'h06);
    phyWrite(8'h22, 8'hFD);
    check(biasSel == 3'd6 && bandgapSel == 3'd5, "R8 halves",
          66'({biasSel, bandgapSel}), 66'({3'd6, 3'd5}));
    check(tstDout == 8'h85, "R8 readback", 66'(tstDout), 66'h85);

    // R10: unimplemented code and reserved bits
    phyWrite(8'h55, 8'hFF);
    check(tstDout == 8'h00, "R10 unimplemented reads 0", 66'(tstDout), 66'h0);
    check(actFields() == expFields(), "R10 no field change", actFields(), expFields());
    phyWrite(8'h19, 8'hFF);
    check(tstDout == 8'h30, "R10 reserved bits of 0x19", 66'(tstDout), 66'h30);
    phyWrite(8'h72, 8'hFF);
    check(thsZeroOvrEn && thsZeroOvr == 6'h3F && tstDout == 8'h7F, "R9 0x72 layout",
          66'(tstDout), 66'h7F);

    // Random stimulus
    for (int it = 0; it < 160; it++) begin
      logic [7:0] a, d;
      a = ($urandom % 4 == 0) ? 8'($urandom) : pickCode($urandom % 8);
      d = 8'($urandom);
      phyWrite(a, d);
      check(tstDout == mdl[a], reqFor(a), 66'(tstDout), 66'(mdl[a]));
      check(actFields() == expFields(), reqFor(a), actFields(), expFields());
      if (it % 16 == 0) begin
        logic [7:0] r;
        r = pickCode($urandom % 8);
        selectCode(r);
        tstEn = 1'b1;
        check(tstDout == mdl[r], "R1 random readback", 66'(tstDout), 66'(mdl[r]));
      end
    end

    // R4: test clear with live edges
    tstClr = 1'b1; settle();
    tstClk = 1'b1; tstEn = 1'b0; tstDin = 8'hFF; settle();
    tstClk = 1'b0; tstEn = 1'b1; tstDin = 8'h17; settle();
    modelClear();
    check(tstDout == 8'h00, "R4 clear dout", 66'(tstDout), 66'h0);
    check(actFields() == expFields(), "R4 clear fields", actFields(), expFields());
    tstClr = 1'b0; tstEn = 1'b0; tstDin = 8'h7F; settle();
    tstClk = 1'b1; settle(); tstEn = 1'b1;
    check(actFields() == expFields(), "R4 code cleared", actFields(), expFields());

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule